// File: doc/BRIEF.md
# Transmit Clock Loss Monitor

This block supervises the transmit line clock of a line interface. A free-running master reference clock acts as a timebase. Each transmit clock rising edge flips a flag in the transmit domain. That flag is synchronized into the master domain, where a change marks transmit clock activity. A miss counter counts master cycles that pass without any activity. When the counter passes its limit, the block raises a loss status. The status drops again as soon as activity comes back. In software control mode, the rising edge of the status can latch an interrupt, which stays set until it is written off.

The same block makes two decisions for the transmit data path. The first is which clock serves as the reference: the transmit clock or the master clock. The second is whether the line driver outputs are enabled or put into high impedance. It also samples the transmit data on the transmit clock edge chosen by configuration. All control and status pins are plain levels. The block has no streaming interface, so no back-pressure rules apply.

Top module: `txclk_loss_monitor`

## Requirements
- R1: `los` rises only once the transmit clock has been still for more than LOSS_LIMIT (default 70) consecutive master clock cycles. It stays low while the transmit clock runs and after a 60-cycle stop. It is high 90 master cycles after the clock stops.
- R2: `los` returns to 0 on its own within 12 master cycles after the transmit clock starts toggling again.
- R3: While `rst_n` is low, and right after it is released, `los` = 0 and `irq` = 0, and the miss count is zero.
- R4: The miss count saturates at LOSS_LIMIT. During an outage of 500 or more master cycles, `los` stays 1 and the count never goes past the limit.
- R5: When `sw_ctrl` = 1 and `irq_mask` = 0, a rising edge of `los` sets `irq`. `irq` then stays 1, even after `los` clears, until a cycle with `irq_clr` = 1 clears it. A loss that continues does not set it again.
- R6: `irq` is never set by a loss when `irq_mask` = 1 or `sw_ctrl` = 0.
- R7: `clk_src` = 1 selects the master clock and 0 selects the transmit clock. If `auto_ones_en` or `ais_en` is 1, `clk_src` = 1 and `patt_clk_sel` is ignored. Otherwise, if `patt_en` = 1, `clk_src` = `patt_clk_sel`. Otherwise, `clk_src` = 0.
- R8: `drv_en` = 0 whenever `mst_clk_ok` = 0, whatever the other inputs are.
- R9: With `mst_clk_ok` = 1 and no loss, `drv_en` = 1. During a loss, `drv_en` = 1 only when `rloop_en` = 1, or when `clk_src` = 1 while a pattern mode (`patt_en`, `auto_ones_en` or `ais_en`) is active. Otherwise `drv_en` = 0.
- R10: With `edge_sel` = 0, `td_smp` shows `td_in` as sampled on the most recent rising edge of `tx_clk`. With `edge_sel` = 1, it shows the value sampled on the most recent falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit line clock being monitored |
| mst_clk | input | 1 | Free-running master reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mst_clk_ok | input | 1 | 1 when the master reference clock is present |
| edge_sel | input | 1 | Transmit data sampling edge: 0 rising, 1 falling |
| td_in | input | 1 | Transmit data from the data path |
| patt_clk_sel | input | 1 | Reference clock for pattern sending: 0 transmit, 1 master |
| patt_en | input | 1 | Pattern sending active (all ones, pseudo-random, loop-up code) |
| auto_ones_en | input | 1 | Automatic all-ones sending active |
| ais_en | input | 1 | Alarm indication sending active |
| rloop_en | input | 1 | Remote loopback active |
| sw_ctrl | input | 1 | Software control mode; enables the interrupt path |
| irq_mask | input | 1 | 1 masks the loss interrupt |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| td_smp | output | 1 | Transmit data sampled on the selected edge |
| los | output | 1 | Transmit clock loss status |
| irq | output | 1 | Latched loss interrupt |
| drv_en | output | 1 | Line driver enable; 0 means high impedance |
| clk_src | output | 1 | Selected reference: 0 transmit clock, 1 master clock |

## Verification
The assertions sample on the master clock. They assume that all mode, mask and clear inputs change away from its rising edge and are steady across it, as a register in the master domain would drive them. The bench meets this by changing every such input on the falling edge of the master clock. The loss timing assertions also assume that the transmit clock is either clearly running or clearly stopped. The bench therefore runs it at one third of the master rate and stops it for whole windows, never with edges so slow that they sit near the limit.

// File: rtl/txm_pkg.sv
package txm_pkg;

  typedef enum logic {
    SRC_TX  = 1'b0,
    SRC_MST = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic patt_en;
    logic patt_clk_sel;
    logic auto_ones_en;
    logic ais_en;
    logic rloop_en;
  } tx_mode_t;

endpackage

// File: rtl/txm_tx_front.sv
module txm_tx_front (
  input  logic tx_clk,
  input  logic rst_n,
  input  logic edge_sel,
  input  logic td_in,
  output logic act_tgl,
  output logic td_smp
);

  logic td_rise_q;
  logic td_fall_q;

  // activity flag flips on every transmit clock rising edge
  always_ff @(posedge tx_clk or negedge rst_n) begin
    if (!rst_n) begin
      act_tgl   <= 1'b0;
      td_rise_q <= 1'b0;
    end else begin
      act_tgl   <= ~act_tgl;
      td_rise_q <= td_in;
    end
  end

  always_ff @(negedge tx_clk or negedge rst_n) begin
    if (!rst_n) td_fall_q <= 1'b0;
    else        td_fall_q <= td_in;
  end

  assign td_smp = edge_sel ? td_fall_q : td_rise_q;

endmodule

// File: rtl/txm_sync_edge.sv
module txm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic change
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];
  end

  assign change = chain_q[LAST] ^ prev_q;

endmodule

// File: rtl/txm_miss_det.sv
module txm_miss_det #(
  parameter int LIMIT = 70,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_seen,
  input  logic          sw_ctrl,
  input  logic          irq_mask,
  input  logic          irq_clr,
  output logic [CW-1:0] miss_cnt,
  output logic          los,
  output logic          irq
);

  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic los_d_q;
  logic los_rise;
  logic irq_set;

  // count master cycles without activity, hold at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               miss_cnt <= '0;
    else if (act_seen)        miss_cnt <= '0;
    else if (miss_cnt != LIM) miss_cnt <= miss_cnt + 1'b1;
  end

  // one more still cycle beyond the limit declares loss
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               los <= 1'b0;
    else if (act_seen)        los <= 1'b0;
    else if (miss_cnt == LIM) los <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) los_d_q <= 1'b0;
    else        los_d_q <= los;
  end

  assign los_rise = los & ~los_d_q;
  assign irq_set  = los_rise & sw_ctrl & ~irq_mask;

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

endmodule

// File: rtl/txm_drive_ctrl.sv
module txm_drive_ctrl
  import txm_pkg::*;
(
  input  tx_mode_t mode,
  input  logic     mst_clk_ok,
  input  logic     los,
  output clk_src_e src,
  output logic     drv_en
);

  logic forced_mst;
  logic patt_active;
  logic mst_pattern;
  logic keep_on;

  assign forced_mst  = mode.auto_ones_en | mode.ais_en;
  assign patt_active = mode.patt_en | forced_mst;

  always_comb begin
    if (forced_mst)        src = SRC_MST;
    else if (mode.patt_en) src = mode.patt_clk_sel ? SRC_MST : SRC_TX;
    else                   src = SRC_TX;
  end

  assign mst_pattern = patt_active & (src == SRC_MST);
  assign keep_on     = mode.rloop_en | mst_pattern;
  assign drv_en      = mst_clk_ok & (~los | keep_on);

endmodule

// File: rtl/txclk_loss_monitor.sv
module txclk_loss_monitor
  import txm_pkg::*;
#(
  parameter int LOSS_LIMIT  = 70,
  parameter int SYNC_STAGES = 2
) (
  input  logic tx_clk,
  input  logic mst_clk,
  input  logic rst_n,
  input  logic mst_clk_ok,
  input  logic edge_sel,
  input  logic td_in,
  input  logic patt_clk_sel,
  input  logic patt_en,
  input  logic auto_ones_en,
  input  logic ais_en,
  input  logic rloop_en,
  input  logic sw_ctrl,
  input  logic irq_mask,
  input  logic irq_clr,
  output logic td_smp,
  output logic los,
  output logic irq,
  output logic drv_en,
  output logic clk_src
);

  localparam int CW = $clog2(LOSS_LIMIT + 1);

  logic          act_tgl;
  logic          act_seen;
  logic [CW-1:0] miss_cnt;
  tx_mode_t      mode;
  clk_src_e      src;

  assign mode.patt_en      = patt_en;
  assign mode.patt_clk_sel = patt_clk_sel;
  assign mode.auto_ones_en = auto_ones_en;
  assign mode.ais_en       = ais_en;
  assign mode.rloop_en     = rloop_en;

  txm_tx_front u_front (
    .tx_clk  (tx_clk),
    .rst_n   (rst_n),
    .edge_sel(edge_sel),
    .td_in   (td_in),
    .act_tgl (act_tgl),
    .td_smp  (td_smp)
  );

  txm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (mst_clk),
    .rst_n   (rst_n),
    .async_in(act_tgl),
    .change  (act_seen)
  );

  txm_miss_det #(.LIMIT(LOSS_LIMIT), .CW(CW)) u_miss (
    .clk     (mst_clk),
    .rst_n   (rst_n),
    .act_seen(act_seen),
    .sw_ctrl (sw_ctrl),
    .irq_mask(irq_mask),
    .irq_clr (irq_clr),
    .miss_cnt(miss_cnt),
    .los     (los),
    .irq     (irq)
  );

  txm_drive_ctrl u_drive (
    .mode      (mode),
    .mst_clk_ok(mst_clk_ok),
    .los       (los),
    .src       (src),
    .drv_en    (drv_en)
  );

  assign clk_src = src;

endmodule

// File: rtl/txm_checker.sv
module txm_checker #(
  parameter int LIMIT = 70,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input logic          mst_clk,
  input logic          rst_n,
  input logic [CW-1:0] miss_cnt,
  input logic          act_seen,
  input logic          los,
  input logic          irq,
  input logic          irq_clr,
  input logic          irq_mask,
  input logic          sw_ctrl,
  input logic          mst_clk_ok,
  input logic          auto_ones_en,
  input logic          ais_en,
  input logic          rloop_en,
  input logic          drv_en,
  input logic          clk_src
);

  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  assert_cnt_sat_R4: assert property (@(posedge mst_clk) disable iff (!rst_n)
    miss_cnt <= LIM);

  assert_los_after_limit_R1: assert property (@(posedge mst_clk) disable iff (!rst_n)
    $rose(los) |-> ($past(miss_cnt) == LIM && !$past(act_seen)));

  assert_los_clears_on_activity_R2: assert property (@(posedge mst_clk) disable iff (!rst_n)
    $fell(los) |-> $past(act_seen));

  assert_irq_set_cause_R5: assert property (@(posedge mst_clk) disable iff (!rst_n)
    $rose(irq) |-> $past(los && sw_ctrl && !irq_mask));

  assert_irq_clear_cause_R5: assert property (@(posedge mst_clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));

  assert_forced_master_R7: assert property (@(posedge mst_clk) disable iff (!rst_n)
    (auto_ones_en || ais_en) |-> clk_src);

  assert_no_master_no_drive_R8: assert property (@(posedge mst_clk) disable iff (!rst_n)
    !mst_clk_ok |-> !drv_en);

  assert_loss_tristate_R9: assert property (@(posedge mst_clk) disable iff (!rst_n)
    (los && !rloop_en && !clk_src) |-> !drv_en);

endmodule

bind txclk_loss_monitor txm_checker #(.LIMIT(LOSS_LIMIT), .CW(CW)) u_chk (
  .mst_clk     (mst_clk),
  .rst_n       (rst_n),
  .miss_cnt    (miss_cnt),
  .act_seen    (act_seen),
  .los         (los),
  .irq         (irq),
  .irq_clr     (irq_clr),
  .irq_mask    (irq_mask),
  .sw_ctrl     (sw_ctrl),
  .mst_clk_ok  (mst_clk_ok),
  .auto_ones_en(auto_ones_en),
  .ais_en      (ais_en),
  .rloop_en    (rloop_en),
  .drv_en      (drv_en),
  .clk_src     (clk_src)
);

// File: tb/tb_txclk_loss_monitor.sv
`timescale 1ns/1ps
module tb_txclk_loss_monitor;

  logic mst_clk = 1'b0;
  logic tx_gen  = 1'b0;
  logic tx_man  = 1'b0;
  logic tx_run  = 1'b0;
  logic tx_clk;
  logic rst_n = 1'b0;
  logic mst_clk_ok = 1'b1, edge_sel = 1'b0, td_in = 1'b0;
  logic patt_clk_sel = 1'b0, patt_en = 1'b0, auto_ones_en = 1'b0, ais_en = 1'b0;
  logic rloop_en = 1'b0, sw_ctrl = 1'b1, irq_mask = 1'b0, irq_clr = 1'b0;
  logic td_smp, los, irq, drv_en, clk_src;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  assign tx_clk = tx_gen ^ tx_man;

  always #2 mst_clk = ~mst_clk;
  always #6 if (tx_run) tx_gen = ~tx_gen;

  txclk_loss_monitor dut (
    .tx_clk(tx_clk), .mst_clk(mst_clk), .rst_n(rst_n), .mst_clk_ok(mst_clk_ok),
    .edge_sel(edge_sel), .td_in(td_in), .patt_clk_sel(patt_clk_sel),
    .patt_en(patt_en), .auto_ones_en(auto_ones_en), .ais_en(ais_en),
    .rloop_en(rloop_en), .sw_ctrl(sw_ctrl), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .td_smp(td_smp), .los(los), .irq(irq),
    .drv_en(drv_en), .clk_src(clk_src)
  );

  // {auto_ones, ais, patt, patt_clk, rloop, mst_ok, exp_src, exp_en_running, exp_en_lost}
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    9'b000001_0_1_0,
    9'b001001_0_1_0,
    9'b001101_1_1_1,
    9'b100001_1_1_1,
    9'b011001_1_1_1,
    9'b000011_0_1_1,
    9'b000101_0_1_0,
    9'b001100_1_0_0,
    9'b100010_1_0_0,
    9'b000000_0_0_0
  };

  task automatic mcyc(input int n);
    repeat (n) @(negedge mst_clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic set_default();
    mst_clk_ok = 1'b1; patt_clk_sel = 1'b0; patt_en = 1'b0;
    auto_ones_en = 1'b0; ais_en = 1'b0; rloop_en = 1'b0;
  endtask

  task automatic walk_table(input bit lost);
    for (int i = 0; i < NV; i++) begin
      auto_ones_en = VEC[i][8]; ais_en = VEC[i][7]; patt_en = VEC[i][6];
      patt_clk_sel = VEC[i][5]; rloop_en = VEC[i][4]; mst_clk_ok = VEC[i][3];
      mcyc(2);
      check(clk_src, VEC[i][2], "R7 clk_src");
      if (!VEC[i][3])
        check(drv_en, lost ? VEC[i][0] : VEC[i][1], "R8 drv_en");
      else
        check(drv_en, lost ? VEC[i][0] : VEC[i][1], "R9 drv_en");
    end
    set_default();
  endtask

  // park tx_clk low, then drive td around one manual rise and fall
  task automatic edge_probe(input logic sel, input logic v_rise, input logic v_fall,
                            input logic exp);
    edge_sel = sel;
    if (tx_clk) begin
      tx_man = ~tx_man;
      #3;
    end
    td_in = v_rise; #2;
    tx_man = ~tx_man; #2;
    td_in = v_fall; #2;
    tx_man = ~tx_man; #2;
    check(td_smp, exp, "R10 td_smp");
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mcyc(5);
    check(los, 1'b0, "R3 los in reset");
    check(irq, 1'b0, "R3 irq in reset");
    check(drv_en, 1'b1, "R3 drv_en in reset");
    rst_n = 1'b1;
    mcyc(1);
    check(los, 1'b0, "R3 los after reset");
    tx_run = 1'b1;
    mcyc(20);
    check(los, 1'b0, "R1 running clock");

    walk_table(1'b0);

    // outage with interrupt enabled
    tx_run = 1'b0;
    mcyc(60);
    check(los, 1'b0, "R1 not early at 60");
    check(irq, 1'b0, "R5 no irq before loss");
    mcyc(30);
    check(los, 1'b1, "R1 set by 90");
    check(irq, 1'b1, "R5 irq on loss");

    walk_table(1'b1);

    irq_clr = 1'b1; mcyc(1); irq_clr = 1'b0;
    mcyc(2);
    check(irq, 1'b0, "R5 irq cleared");
    mcyc(500);
    check(los, 1'b1, "R4 long outage keeps loss");
    check(irq, 1'b0, "R5 no re-set during loss");

    tx_run = 1'b1;
    mcyc(12);
    check(los, 1'b0, "R2 clears on return");

    // masked interrupt
    irq_mask = 1'b1;
    tx_run = 1'b0; mcyc(100);
    check(los, 1'b1, "R1 loss with mask");
    check(irq, 1'b0, "R6 masked");
    tx_run = 1'b1; mcyc(12);
    check(los, 1'b0, "R2 clears after masked loss");
    check(irq, 1'b0, "R6 masked after return");

    // hardware mode
    irq_mask = 1'b0; sw_ctrl = 1'b0;
    tx_run = 1'b0; mcyc(100);
    check(irq, 1'b0, "R6 hardware mode");
    tx_run = 1'b1; mcyc(12);

    // latch holds after loss ends
    sw_ctrl = 1'b1;
    tx_run = 1'b0; mcyc(100);
    check(irq, 1'b1, "R5 set again");
    tx_run = 1'b1; mcyc(12);
    check(los, 1'b0, "R2 clears again");
    check(irq, 1'b1, "R5 latched after loss ends");
    irq_clr = 1'b1; mcyc(1); irq_clr = 1'b0; mcyc(1);
    check(irq, 1'b0, "R5 write-one clear");

    // edge selection of data sampling
    tx_run = 1'b0;
    mcyc(4);
    edge_probe(1'b0, 1'b1, 1'b0, 1'b1);
    edge_probe(1'b1, 1'b1, 1'b0, 1'b0);
    edge_probe(1'b0, 1'b0, 1'b1, 1'b0);
    edge_probe(1'b1, 1'b0, 1'b1, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule